// File: doc/BRIEF.md
# ADC Sample FIFO with Sticky Error Flags

This block buffers up to four 12-bit converter results between the converter and a register bus. A sample enters either on a converter-done strobe or on a bus write of a dummy value, which lets software exercise the data path with no converter running. A bus read strobe pops the oldest sample into a registered read-data output. The output keeps that value until the next successful pop.

A five-bit status word reports whether the FIFO is empty, almost full, full, overflowed or underflowed. The two error flags are sticky and each one freezes one side of the FIFO. Overflow blocks every further push. Underflow blocks every further pop, so reads keep returning the last sample. A flush strobe empties the FIFO and clears both flags. It leaves the read-data output unchanged.

Top module: `adc_sample_fifo`

## Requirements
- R1: The FIFO stores up to four 12-bit samples and returns them in arrival order.
- R2: Status bit 0 (empty) is 1 after reset and whenever no sample is stored.
- R3: Status bit 1 (almost full) is 1 only when exactly three samples are stored. Status bit 2 (full) is 1 when four samples are stored, and almost full is then 0.
- R4: A push while full is dropped and sets status bit 4 (overflow). While overflow is set, no push is accepted.
- R5: A read while empty leaves the read data at the last sample read and sets status bit 3 (underflow). While underflow is set, reads pop nothing and the read data does not change.
- R6: Overflow and underflow stay set until a flush, whatever pushes or reads occur in the meantime.
- R7: A bus write pushes its 12-bit value as a sample, in the same way as a converter result.
- R8: When a converter push and a bus write occur in the same cycle, the converter sample is stored and the bus value is discarded.
- R9: A flush empties the FIFO, clears both sticky flags, ignores any push or read in the same cycle, and keeps the read data unchanged.
- R10: The status word is {overflow, underflow, full, almost full, empty}, with bit 4 on the left and bit 0 on the right.
- R11: The read data and the status change at the clock edge that samples the strobe causing the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_valid_i | input | 1 | Converter result strobe |
| conv_data_i | input | 12 | Converter result |
| bus_wr_i | input | 1 | Bus write strobe that pushes a dummy sample |
| bus_wdata_i | input | 12 | Dummy sample value |
| bus_rd_i | input | 1 | Bus read strobe that pops a sample |
| flush_i | input | 1 | Flush command |
| rd_data_o | output | 12 | Last popped sample |
| status_o | output | 5 | {overflow, underflow, full, almost full, empty} |

## Verification
Every result appears one clock edge after the strobe that causes it. A pop updates the read data at that edge. A push, pop or flush changes the count, and therefore the status word, at that edge. The bench applies each strobe at a falling edge and lifts it at the next falling edge. It then compares the read data and all five status bits against a model held in the bench. Directed sequences cover the corner cases, and a long pseudo-random run of mixed strobes follows them.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;
  localparam int unsigned STS_W     = 5;
  localparam int unsigned STS_EMPTY = 0;
  localparam int unsigned STS_AFULL = 1;
  localparam int unsigned STS_FULL  = 2;
  localparam int unsigned STS_UNF   = 3;
  localparam int unsigned STS_OVF   = 4;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic full;
    logic afull;
    logic empty;
  } fifo_sts_t;
endpackage

// File: rtl/adc_fifo_push_arb.sv
module adc_fifo_push_arb #(
  parameter int unsigned DW = 12
) (
  input  logic          conv_valid_i,
  input  logic [DW-1:0] conv_data_i,
  input  logic          bus_wr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic          push_o,
  output logic [DW-1:0] push_data_o
);
  // R8: converter result takes precedence over bus dummy write
  always_comb begin
    push_o      = conv_valid_i | bus_wr_i;
    push_data_o = conv_valid_i ? conv_data_i : bus_wdata_i;
  end
endmodule

// File: rtl/adc_fifo_mem.sv
module adc_fifo_mem #(
  parameter int unsigned DW    = 12,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           slot_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))    slot_q[g] <= wdata_i;
    end
  end

  assign rdata_o = slot_q[raddr_i];
endmodule

// File: rtl/adc_fifo_ctrl.sv
module adc_fifo_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic          we_o,
  output logic          re_o,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q, unf_q;
  logic          full, empty;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  // R4/R5: a raised sticky flag freezes its own pointer
  assign we_o  = push_i & ~flush_i & ~full  & ~ovf_q;
  assign re_o  = pop_i  & ~flush_i & ~empty & ~unf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else if (flush_i) begin // R9
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      if (we_o) wptr_q <= wrap_inc(wptr_q);
      if (re_o) rptr_q <= wrap_inc(rptr_q);
      case ({we_o, re_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_i && full) ovf_q <= 1'b1; // R6: sticky
      if (pop_i && empty) unf_q <= 1'b1;
    end
  end

  assign wptr_o  = wptr_q;
  assign rptr_o  = rptr_q;
  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo
  import adc_fifo_pkg::*;
#(
  parameter int unsigned DW    = 12,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_valid_i,
  input  logic [DW-1:0]    conv_data_i,
  input  logic             bus_wr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  input  logic             bus_rd_i,
  input  logic             flush_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [STS_W-1:0] status_o
);
  logic          push;
  logic [DW-1:0] push_data;
  logic          we, re;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          ovf, unf;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] rd_q;
  fifo_sts_t     sts;

  adc_fifo_push_arb #(.DW(DW)) u_arb (
    .conv_valid_i(conv_valid_i),
    .conv_data_i (conv_data_i),
    .bus_wr_i    (bus_wr_i),
    .bus_wdata_i (bus_wdata_i),
    .push_o      (push),
    .push_data_o (push_data)
  );

  adc_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (bus_rd_i),
    .flush_i(flush_i),
    .we_o   (we),
    .re_o   (re),
    .wptr_o (wptr),
    .rptr_o (rptr),
    .count_o(count),
    .ovf_o  (ovf),
    .unf_o  (unf)
  );

  adc_fifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .waddr_i(wptr),
    .wdata_i(push_data),
    .raddr_i(rptr),
    .rdata_o(mem_rdata)
  );

  // R5/R11: read data only moves on an accepted pop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rd_q <= '0;
    else if (re)  rd_q <= mem_rdata;
  end

  // R10
  always_comb begin
    sts.empty = (count == '0);
    sts.afull = (count == CW'(DEPTH - 1));
    sts.full  = (count == CW'(DEPTH));
    sts.unf   = unf;
    sts.ovf   = ovf;
  end

  assign rd_data_o = rd_q;
  assign status_o  = sts;
endmodule

// File: rtl/adc_sample_fifo_chk.sv
module adc_sample_fifo_chk #(
  parameter int unsigned DW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          conv_valid_i,
  input logic [DW-1:0] conv_data_i,
  input logic          bus_wr_i,
  input logic [DW-1:0] bus_wdata_i,
  input logic          bus_rd_i,
  input logic          flush_i,
  input logic [DW-1:0] rd_data_o,
  input logic [4:0]    status_o
);
  a_r3_levels_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status_o[2:0]));

  a_r4_overflow_freezes_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[4] && !flush_i && !bus_rd_i) |=> $stable(status_o[2:0]));

  a_r5_underflow_holds_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3] && !flush_i) |=> $stable(rd_data_o));

  a_r6_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[4] && !flush_i) |=> status_o[4]);

  a_r6_underflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3] && !flush_i) |=> status_o[3]);

  a_r9_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (status_o == 5'b00001));

  a_r9_flush_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> $stable(rd_data_o));

  a_r2_empty_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && bus_rd_i && !flush_i) |=> (status_o[3] && $stable(rd_data_o)));
endmodule

bind adc_sample_fifo adc_sample_fifo_chk #(.DW(DW)) u_chk (.*);

// File: tb/adc_sample_fifo_test.sv
`timescale 1ns/1ps
module adc_sample_fifo_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        conv_valid_i = 1'b0;
  logic [11:0] conv_data_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [11:0] bus_wdata_i = '0;
  logic        bus_rd_i = 1'b0;
  logic        flush_i = 1'b0;
  logic [11:0] rd_data_o;
  logic [4:0]  status_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [11:0] mq [4];
  int          m_cnt = 0;
  logic        m_ovf = 1'b0, m_unf = 1'b0;
  logic [11:0] m_last = '0;

  always #4 clk_i = ~clk_i;

  adc_sample_fifo uut (.*);

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [4:0] ew;
    ew = {m_ovf, m_unf, m_cnt == 4, m_cnt == 3, m_cnt == 0};
    chk(rd_data_o == m_last, {tag, " R1 data"}, int'(rd_data_o), int'(m_last));
    chk(status_o[0] == ew[0], "R2 empty", int'(status_o[0]), int'(ew[0]));
    chk(status_o[2:1] == ew[2:1], "R3 afull/full", int'(status_o[2:1]), int'(ew[2:1]));
    chk(status_o[4] == ew[4], "R4 overflow", int'(status_o[4]), int'(ew[4]));
    chk(status_o[3] == ew[3], "R5 underflow", int'(status_o[3]), int'(ew[3]));
    chk(status_o == ew, {tag, " R10 word"}, int'(status_o), int'(ew));
  endtask

  task automatic model_edge(input logic cv, input logic [11:0] cd, input logic bw,
                            input logic [11:0] bd, input logic rd, input logic fl);
    int pre;
    pre = m_cnt;
    if (fl) begin
      m_cnt = 0; m_ovf = 1'b0; m_unf = 1'b0;
    end else begin
      if (rd) begin
        if (pre == 0) m_unf = 1'b1;
        else if (!m_unf) begin
          m_last = mq[0];
          for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
          m_cnt--;
        end
      end
      if (cv || bw) begin
        if (pre == 4) m_ovf = 1'b1;
        else if (!m_ovf) begin
          mq[m_cnt] = cv ? cd : bd;
          m_cnt++;
        end
      end
    end
  endtask

  // one strobe cycle: drive at falling edge, result due at the next rising edge (R11)
  task automatic step(input logic cv, input logic [11:0] cd, input logic bw,
                      input logic [11:0] bd, input logic rd, input logic fl, input string tag);
    conv_valid_i = cv; conv_data_i = cd; bus_wr_i = bw; bus_wdata_i = bd;
    bus_rd_i = rd; flush_i = fl;
    @(posedge clk_i);
    model_edge(cv, cd, bw, bd, rd, fl);
    @(negedge clk_i);
    conv_valid_i = 1'b0; bus_wr_i = 1'b0; bus_rd_i = 1'b0; flush_i = 1'b0;
    check_all(tag);
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R2 reset");

    for (int i = 1; i <= 4; i++) step(1, 12'h100 + 12'(i), 0, 0, 0, 0, "R1 fill");
    step(1, 12'h1FF, 0, 0, 0, 0, "R4 push full");
    step(0, 0, 0, 0, 1, 0, "R1 pop");
    step(1, 12'h2EE, 0, 0, 0, 0, "R4 push after ovf");
    step(0, 0, 1, 12'h3DD, 0, 0, "R6 ovf sticky");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, "R1 drain");
    step(0, 0, 0, 0, 1, 0, "R5 read empty");
    step(0, 0, 0, 0, 0, 1, "R9 flush");
    step(0, 0, 1, 12'hABC, 0, 0, "R7 bus push");
    step(0, 0, 0, 0, 1, 0, "R7 bus pop");
    step(0, 0, 0, 0, 1, 0, "R5 underflow");
    step(1, 12'h321, 0, 0, 0, 0, "R6 push under unf");
    step(0, 0, 0, 0, 1, 0, "R5 frozen read");
    step(0, 0, 0, 0, 0, 0, "R6 unf sticky");
    step(1, 12'h777, 0, 0, 1, 1, "R9 flush wins");
    step(1, 12'h555, 1, 12'h666, 0, 0, "R8 collide");
    step(0, 0, 0, 0, 1, 0, "R8 pop");
    step(0, 0, 0, 0, 1, 0, "R8 empty after");

    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] r;
      r = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(r[1:0] == 2'b00, {lfsr[11:0]}, r[3:2] == 2'b01, ~lfsr[11:0],
           r[5:4] != 2'b00 && r[6], r[10:7] == 4'hF, "R11 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule